// File: doc/BRIEF.md
# Prioritized Serial Interrupt Controller

This block is the interrupt logic of one serial channel. It takes four raw conditions: a receiver line-status error event, a receive-data-ready level, a transmit-holding-empty level and a modem-status change event. It also holds a four-bit interrupt enable register. From these it builds a status code that always names the highest-priority source that is both pending and enabled. That code is readable at any time.

A read of the status code is presented as a strobe, and it acknowledges only the transmit-empty source. The line-status and modem-status sources are held until their own status registers are read, and those reads arrive as clear strobes. Receive data ready follows its input level. The external interrupt pin is registered and has a separate output-enable. The enable is on when an override strap is high or when a modem-control gate bit is set. Otherwise the pin floats.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the status code reads 0x01, and both irqData and irqOe are 0.
- R2: A write (enWrite) stores enWData[3:0] into the enable register. enRead[7:4] always reads 0. The enable bits are: bit0 receive ready, bit1 transmit empty, bit2 line status, bit3 modem status.
- R3: The status code is 0x06 for line status, 0x04 for receive ready, 0x02 for transmit empty, 0x00 for modem status and 0x01 when nothing is active. Priority runs in that order, highest first.
- R4: A source whose enable bit is 0 never shows in the status code. Its pending state is kept and appears once the bit is set.
- R5: A statusRead strobe taken while the code is 0x02 clears the transmit-empty source. The source is set again on the next rising edge of thrEmpty.
- R6: A statusRead strobe leaves the line-status, modem-status and receive-ready sources untouched. It also leaves the transmit-empty source untouched whenever a higher source is reported.
- R7: A thrWrite strobe clears the transmit-empty source, and the clear wins over a simultaneous set.
- R8: Line status is set by lineEvent and modem status by modemEvent. Each stays pending until lineClear or modemClear respectively, and a new event in the same cycle as a clear keeps it pending.
- R9: Receive ready is active exactly while rxReady is 1, with no latching.
- R10: irqOe takes the value (forceOn OR intGate) one cycle later. irqData takes the value "status code bit0 is 0" one cycle later.
- R11: Status bits 7:4 always read 0, and bit0 is 0 exactly when some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrite | input | 1 | Enable register write strobe |
| enWData | input | 8 | Enable register write data |
| enRead | output | 8 | Enable register contents |
| statusRead | input | 1 | Status code read strobe |
| statusCode | output | 8 | Current interrupt status code |
| rxReady | input | 1 | Receive holding register full (level) |
| thrEmpty | input | 1 | Transmit holding register empty (level) |
| thrWrite | input | 1 | Transmit holding register write strobe |
| lineEvent | input | 1 | Line status error event |
| lineClear | input | 1 | Line status register read |
| modemEvent | input | 1 | Modem status change event |
| modemClear | input | 1 | Modem status register read |
| forceOn | input | 1 | Strap that keeps the interrupt pin driven |
| intGate | input | 1 | Modem-control gate bit for the interrupt pin |
| irqData | output | 1 | Registered interrupt level |
| irqOe | output | 1 | Registered output enable of the interrupt pin |

## Verification
The hardest condition to reach is a status read that lands while transmit-empty is pending but hidden below a higher source. Such a read must leave it pending. The stimulus holds rxReady high over the read, then drops rxReady and expects 0x02 to surface. A close second is a line event and a line clear arriving in the same cycle. The stimulus produces this deliberately, and the random phase produces it by chance, while a reference model is compared on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 4;

  // index order is priority order, highest first
  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_RX    = 2'd1,
    SRC_TX    = 2'd2,
    SRC_MODEM = 2'd3
  } src_e;

  typedef struct packed {
    logic ierLoad;
    logic txSet;
    logic txClr;
  } strobes_t;

  // enable-register bit that gates each source
  function automatic int enBitOf(input int src);
    case (src)
      0:       return 2;
      1:       return 0;
      2:       return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic setI,
  input  logic clrI,
  output logic flagO
);
  logic nextVal;

  generate
    if (SET_WINS) begin : g_setWins
      assign nextVal = setI | (flagO & ~clrI);
    end else begin : g_clrWins
      assign nextVal = ~clrI & (setI | flagO);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) flagO <= 1'b0;
    else       flagO <= nextVal;
  end
endmodule

// File: rtl/irq_prio_seq.sv
module irq_prio_seq
  import irq_prio_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enWrite,
  input  logic     statusRead,
  input  logic     thrWrite,
  input  logic     thrEmpty,
  input  src_e     topSrc,
  input  logic     anyActive,
  output strobes_t strb
);
  logic prevEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) prevEmpty <= 1'b0;
    else       prevEmpty <= thrEmpty;
  end

  always_comb begin
    strb.ierLoad = enWrite;
    strb.txSet   = thrEmpty & ~prevEmpty;
    strb.txClr   = thrWrite | (statusRead & anyActive & (topSrc == SRC_TX));
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] enWData,
  input  logic              rxReady,
  input  logic              lineEvent,
  input  logic              lineClear,
  input  logic              modemEvent,
  input  logic              modemClear,
  input  logic              forceOn,
  input  logic              intGate,
  output logic [DATA_W-1:0] enRead,
  output logic [DATA_W-1:0] statusCode,
  output src_e              topSrc,
  output logic              anyActive,
  output logic              irqData,
  output logic              irqOe
);
  localparam int HI_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] ierReg;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] active;
  logic [CODE_W-1:0]  codeField;
  logic               unusedHiBits;

  assign unusedHiBits = ^enWData[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN)             ierReg <= '0;
    else if (strb.ierLoad) ierReg <= enWData[NUM_SRC-1:0];
  end

  irq_sticky_flag #(.SET_WINS(1'b1)) u_line (
    .clk(clk), .rstN(rstN), .setI(lineEvent), .clrI(lineClear), .flagO(pend[SRC_LINE]));
  irq_sticky_flag #(.SET_WINS(1'b1)) u_modem (
    .clk(clk), .rstN(rstN), .setI(modemEvent), .clrI(modemClear), .flagO(pend[SRC_MODEM]));
  irq_sticky_flag #(.SET_WINS(1'b0)) u_tx (
    .clk(clk), .rstN(rstN), .setI(strb.txSet), .clrI(strb.txClr), .flagO(pend[SRC_TX]));
  assign pend[SRC_RX] = rxReady;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign active[i] = pend[i] & ierReg[enBitOf(i)];
    end
  endgenerate

  always_comb begin
    anyActive = 1'b0;
    topSrc    = SRC_MODEM;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        anyActive = 1'b1;
        topSrc    = src_e'(i);
      end
    end
    if (anyActive) codeField = CODE_W'((NUM_SRC - 1 - int'(topSrc)) * 2);
    else           codeField = CODE_W'(1);
  end

  assign statusCode = {{(DATA_W-CODE_W){1'b0}}, codeField};
  assign enRead     = {{HI_W{1'b0}}, ierReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqData <= 1'b0;
      irqOe   <= 1'b0;
    end else begin
      irqData <= anyActive;
      irqOe   <= forceOn | intGate;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrite,
  input  logic [DATA_W-1:0] enWData,
  output logic [DATA_W-1:0] enRead,
  input  logic              statusRead,
  output logic [DATA_W-1:0] statusCode,
  input  logic              rxReady,
  input  logic              thrEmpty,
  input  logic              thrWrite,
  input  logic              lineEvent,
  input  logic              lineClear,
  input  logic              modemEvent,
  input  logic              modemClear,
  input  logic              forceOn,
  input  logic              intGate,
  output logic              irqData,
  output logic              irqOe
);
  strobes_t strb;
  src_e     topSrc;
  logic     anyActive;

  irq_prio_seq u_seq (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .statusRead(statusRead),
    .thrWrite(thrWrite), .thrEmpty(thrEmpty), .topSrc(topSrc),
    .anyActive(anyActive), .strb(strb));

  irq_prio_dp #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .enWData(enWData), .rxReady(rxReady),
    .lineEvent(lineEvent), .lineClear(lineClear), .modemEvent(modemEvent),
    .modemClear(modemClear), .forceOn(forceOn), .intGate(intGate),
    .enRead(enRead), .statusCode(statusCode), .topSrc(topSrc),
    .anyActive(anyActive), .irqData(irqData), .irqOe(irqOe));
endmodule

// File: rtl/irq_prio_checks.sv
module irq_prio_checks (
  input logic       clk,
  input logic       rstN,
  input logic       enWrite,
  input logic [7:0] enRead,
  input logic       statusRead,
  input logic [7:0] statusCode,
  input logic       thrWrite,
  input logic       lineClear,
  input logic       forceOn,
  input logic       intGate,
  input logic       irqData,
  input logic       irqOe
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    enRead[7:4] == 4'h0);

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusCode[7:4] == 4'h0);

  a_r4_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enRead[3:0] == 4'h0) |-> (statusCode == 8'h01));

  a_r5_read_acks_tx: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && statusCode == 8'h02) |=> (statusCode != 8'h02));

  a_r7_write_clears_tx: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> (statusCode != 8'h02));

  a_r8_line_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode == 8'h06 && !lineClear && !enWrite) |=> (statusCode == 8'h06));

  a_r10_oe_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOe == $past(forceOn || intGate)));

  a_r10_data_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqData == !$past(statusCode[0])));
endmodule

bind irq_prio_ctrl irq_prio_checks u_checks (.*);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enWrite = 1'b0;
  logic [7:0] enWData = 8'h00;
  logic [7:0] enRead;
  logic       statusRead = 1'b0;
  logic [7:0] statusCode;
  logic       rxReady = 1'b0;
  logic       thrEmpty = 1'b0;
  logic       thrWrite = 1'b0;
  logic       lineEvent = 1'b0;
  logic       lineClear = 1'b0;
  logic       modemEvent = 1'b0;
  logic       modemClear = 1'b0;
  logic       forceOn = 1'b0;
  logic       intGate = 1'b0;
  logic       irqData;
  logic       irqOe;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  // reference model state
  int  mIer = 0;
  bit  mLine = 0, mModem = 0, mTx = 0, mPrevE = 0, mIrqD = 0, mOe = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWData(enWData), .enRead(enRead),
    .statusRead(statusRead), .statusCode(statusCode), .rxReady(rxReady),
    .thrEmpty(thrEmpty), .thrWrite(thrWrite), .lineEvent(lineEvent),
    .lineClear(lineClear), .modemEvent(modemEvent), .modemClear(modemClear),
    .forceOn(forceOn), .intGate(intGate), .irqData(irqData), .irqOe(irqOe));

  function automatic int modelCode();
    if (mLine && mIer[2])        return 6;
    else if (rxReady && mIer[0]) return 4;
    else if (mTx && mIer[1])     return 2;
    else if (mModem && mIer[3])  return 0;
    return 1;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(int'(statusCode), modelCode(), "R3 code vs model");
    check(int'(enRead), mIer, "R2 enables vs model");
    check(int'(irqData), int'(mIrqD), "R10 irqData vs model");
    check(int'(irqOe), int'(mOe), "R10 irqOe vs model");
  endtask

  // one clock: advance model with held inputs, then compare after the edge
  task automatic step();
    int  c;
    bit  txSet, txClr;
    c = modelCode();
    @(posedge clk);
    #1;
    txSet = thrEmpty && !mPrevE;
    txClr = thrWrite || (statusRead && c == 2);
    if (enWrite) mIer = int'(enWData) & 'hF;
    mLine  = lineEvent  ? 1'b1 : (lineClear  ? 1'b0 : mLine);
    mModem = modemEvent ? 1'b1 : (modemClear ? 1'b0 : mModem);
    mTx    = txClr ? 1'b0 : (txSet ? 1'b1 : mTx);
    mPrevE = thrEmpty;
    mIrqD  = (c != 1);
    mOe    = forceOn || intGate;
    compareAll();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(int'(statusCode), 8'h01, "R1 reset code");
    check(int'(enRead), 8'h00, "R1 reset enables");
    check(int'(irqOe), 0, "R1 reset oe");
    check(int'(irqData), 0, "R1 reset data");
    @(negedge clk);
    rstN = 1'b1;

    // R2 enable write, upper bits dropped
    enWrite = 1; enWData = 8'hFF; step(); enWrite = 0;
    check(int'(enRead), 8'h0F, "R2 upper bits read 0");

    // R3 all four pending
    lineEvent = 1; modemEvent = 1; rxReady = 1; thrEmpty = 1; step();
    lineEvent = 0; modemEvent = 0;
    check(int'(statusCode), 8'h06, "R3 line highest");

    statusRead = 1; step(); statusRead = 0;
    check(int'(statusCode), 8'h06, "R6 read keeps line");

    lineClear = 1; step(); lineClear = 0;
    check(int'(statusCode), 8'h04, "R3 rx next");

    statusRead = 1; step(); statusRead = 0;
    check(int'(statusCode), 8'h04, "R9 rx held by level");

    rxReady = 0; step();
    check(int'(statusCode), 8'h02, "R6 hidden tx survives read");

    statusRead = 1; step(); statusRead = 0;
    check(int'(statusCode), 8'h00, "R5 read acks tx");

    modemClear = 1; step(); modemClear = 0;
    check(int'(statusCode), 8'h01, "R8 modem cleared");
    check(int'(statusCode[0]), 1, "R11 bit0 idle");

    thrEmpty = 0; step(); thrEmpty = 1; step();
    check(int'(statusCode), 8'h02, "R5 tx re-armed");
    check(int'(statusCode[0]), 0, "R11 bit0 pending");

    thrWrite = 1; step(); thrWrite = 0;
    check(int'(statusCode), 8'h01, "R7 write clears tx");

    // R4 masking keeps pending state
    enWrite = 1; enWData = 8'h0B; lineEvent = 1; step(); enWrite = 0; lineEvent = 0;
    check(int'(statusCode), 8'h01, "R4 line masked");
    enWrite = 1; enWData = 8'h0F; step(); enWrite = 0;
    check(int'(statusCode), 8'h06, "R4 line shows once enabled");

    lineEvent = 1; lineClear = 1; step(); lineEvent = 0; lineClear = 0;
    check(int'(statusCode), 8'h06, "R8 event wins over clear");
    lineClear = 1; step(); lineClear = 0;
    check(int'(statusCode), 8'h01, "R8 line cleared");

    // R10 pin gating
    modemEvent = 1; step(); modemEvent = 0;
    step();
    check(int'(irqData), 1, "R10 data high");
    check(int'(irqOe), 0, "R10 floating");
    intGate = 1; step();
    check(int'(irqOe), 1, "R10 gate bit drives");
    intGate = 0; forceOn = 1; step();
    check(int'(irqOe), 1, "R10 strap drives");
    forceOn = 0; modemClear = 1; step(); modemClear = 0;
    check(int'(irqOe), 0, "R10 floating again");
    step();
    check(int'(irqData), 0, "R10 data low");

    // random phase, model compared each clock
    for (int k = 0; k < 4000; k++) begin
      enWrite    = ($urandom_range(0, 15) == 0);
      enWData    = 8'($urandom);
      statusRead = ($urandom_range(0, 3) == 0);
      rxReady    = ($urandom_range(0, 2) == 0) ? ~rxReady : rxReady;
      thrEmpty   = ($urandom_range(0, 3) == 0) ? ~thrEmpty : thrEmpty;
      thrWrite   = ($urandom_range(0, 7) == 0);
      lineEvent  = ($urandom_range(0, 9) == 0);
      lineClear  = ($urandom_range(0, 5) == 0);
      modemEvent = ($urandom_range(0, 9) == 0);
      modemClear = ($urandom_range(0, 5) == 0);
      forceOn    = ($urandom_range(0, 7) == 0);
      intGate    = ($urandom_range(0, 1) == 0);
      step();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule